// File: doc/BRIEF.md
# Sequential Byte-Program Sequencer

This block sits behind the serial command decoder of a flash-style memory and turns decoded command strobes into self-timed byte writes. It owns three status bits: the busy flag, the write-enable latch and the sequential-mode flag. It tracks the address of the byte most recently written, so that a sequential run only needs an address on its first command. Every later command in the run carries a data byte alone.

The decoder raises one strobe for one clock when a command frame is complete and chip select has been released. Each strobe is paired with the captured address and data byte. The strobes are: a single-byte program, a sequential-run start, a sequential-run continuation, write-enable and write-disable.

For every candidate target, the sequencer puts the address on `chk_addr` and reads back a combinational protection verdict. An accepted write becomes a one-clock request to the array, and busy then stays high for a parameterised number of clocks. A sequential run never wraps. It ends by itself, and drops the write-enable latch, once the byte just written is the last address of the space or the next address is protected.

Top module: `aai_prog_seq`

## Requirements
- R1: A single-byte program strobe (`st_byte`) writes `cmd_data` to `cmd_addr` only if the write-enable latch is set. The latch reads 0 once busy has fallen again.
- R2: A sequential-start strobe (`st_seq`) with the latch set writes `cmd_data` to `cmd_addr` and sets `seq_mode`. `seq_mode` stays set after busy falls, unless R5 applies.
- R3: While `seq_mode` is set, each continuation strobe (`st_next`) writes its `cmd_data` to the address one above the byte last written.
- R4: A write-disable strobe (`st_wrdi`) clears both the write-enable latch and `seq_mode`. A later `st_next` writes nothing.
- R5: A sequential run does not wrap. When a write completes at the all-ones address, or the following address is protected, `seq_mode` and the latch both clear, and a further `st_next` writes nothing.
- R6: A program or start strobe whose target is reported protected issues no write request, leaves busy low and leaves the latch unchanged.
- R7: Each accepted write raises `wr_req` for one clock and holds busy high for exactly `BUSY_CYC` clocks.
- R8: A write-enable strobe (`st_wren`) sets the write-enable latch.
- R9: Any strobe arriving while busy is high is discarded.
- R10: An `st_next` strobe while `seq_mode` is clear is ignored. An `st_byte` or `st_seq` while `seq_mode` is set is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears busy, latch and mode |
| st_wren | input | 1 | Write-enable command strobe |
| st_wrdi | input | 1 | Write-disable command strobe |
| st_byte | input | 1 | Single-byte program strobe (with address and data) |
| st_seq | input | 1 | Sequential-run start strobe (with address and data) |
| st_next | input | 1 | Sequential-run continuation strobe (data only) |
| cmd_addr | input | ADDR_W | Address captured by the decoder |
| cmd_data | input | 8 | Data byte captured by the decoder |
| chk_addr | output | ADDR_W | Address presented to the protection check |
| chk_protected | input | 1 | Protection verdict for `chk_addr`, combinational |
| wr_req | output | 1 | One-clock byte-write request to the array |
| wr_addr | output | ADDR_W | Byte address of the request |
| wr_data | output | 8 | Byte value of the request |
| busy | output | 1 | Self-timed write in progress |
| wel | output | 1 | Write-enable latch |
| seq_mode | output | 1 | Sequential-run mode flag |

## Verification
A wrong pointer value appears at the first continuation write after it goes wrong, as a byte landing on the wrong array address. The bench reads the array model back after each run to catch this. A latch or mode bit that fails to clear becomes visible on the status outputs in the clock after busy falls. A timer fault shows up as a busy pulse of the wrong length, which the bench measures in clocks on every write.

// File: rtl/aai_pkg.sv
package aai_pkg;
   typedef enum logic [2:0] {
      ACT_NONE = 3'd0,
      ACT_WREN = 3'd1,
      ACT_WRDI = 3'd2,
      ACT_BYTE = 3'd3,
      ACT_SEQ  = 3'd4,
      ACT_NEXT = 3'd5
   } act_t;
endpackage

// File: rtl/aai_busy_timer.sv
module aai_busy_timer #(
   parameter int BUSY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;

   if (BUSY_CYC < 1) begin : g_bad_cyc
      $error("BUSY_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (done)  busy <= 1'b0;
   end

   if (BUSY_CYC == 1) begin : g_one
      assign done = busy;
   end else begin : g_cnt
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (start)       cnt <= CW'(BUSY_CYC - 1);
         else if (busy && cnt != '0) cnt <= cnt - 1'b1;
      end
      assign done = busy && (cnt == '0);

      assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
         int'(cnt) <= BUSY_CYC - 1);
      assert_idle_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !busy |-> cnt == '0);
   end

   assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done |-> !start);
endmodule

// File: rtl/aai_addr_track.sv
module aai_addr_track #(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   output logic [ADDR_W-1:0] nxt,
   output logic              at_top
);
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

   if (ADDR_W < 2) begin : g_bad_w
      $error("ADDR_W must be at least 2");
   end

   logic [ADDR_W-1:0] last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last <= '0;
      else if (load) last <= load_addr;
   end

   assign nxt    = last + 1'b1;
   assign at_top = (last == TOP);
endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
   import aai_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int BUSY_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_wren,
   input  logic              st_wrdi,
   input  logic              st_byte,
   input  logic              st_seq,
   input  logic              st_next,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   output logic [ADDR_W-1:0] chk_addr,
   input  logic              chk_protected,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              busy,
   output logic              wel,
   output logic              seq_mode
);
   act_t              act;
   logic              done;
   logic [ADDR_W-1:0] nxt;
   logic              at_top;
   logic              fire_byte, fire_seq, fire_next, fire;
   logic              run_end;

   // decode, busy discards everything
   always_comb begin
      act = ACT_NONE;
      if (!busy) begin
         if (st_wrdi)      act = ACT_WRDI;
         else if (st_wren) act = ACT_WREN;
         else if (st_byte) act = ACT_BYTE;
         else if (st_seq)  act = ACT_SEQ;
         else if (st_next) act = ACT_NEXT;
      end
   end

   assign chk_addr  = (act == ACT_BYTE || act == ACT_SEQ) ? cmd_addr : nxt;
   assign fire_byte = (act == ACT_BYTE) && wel && !seq_mode && !chk_protected;
   assign fire_seq  = (act == ACT_SEQ)  && wel && !seq_mode && !chk_protected;
   assign fire_next = (act == ACT_NEXT) && seq_mode && !chk_protected;
   assign fire      = fire_byte || fire_seq || fire_next;
   assign run_end   = done && seq_mode && (at_top || chk_protected);

   aai_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(fire), .busy(busy), .done(done));

   aai_addr_track #(.ADDR_W(ADDR_W)) u_track (
      .clk(clk), .rst_n(rst_n), .load(fire),
      .load_addr(fire_next ? nxt : cmd_addr),
      .nxt(nxt), .at_top(at_top));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_req  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_req <= fire;
         if (fire) begin
            wr_addr <= fire_next ? nxt : cmd_addr;
            wr_data <= cmd_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel      <= 1'b0;
         seq_mode <= 1'b0;
      end else begin
         if (act == ACT_WREN) wel <= 1'b1;
         if (act == ACT_WRDI) begin
            wel      <= 1'b0;
            seq_mode <= 1'b0;
         end
         if (fire_seq) seq_mode <= 1'b1;
         if (done && !seq_mode) wel <= 1'b0;
         if (run_end) begin
            wel      <= 1'b0;
            seq_mode <= 1'b0;
         end
      end
   end

   assert_req_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> busy);
   assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> !wr_req);
   assert_start_has_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> wr_req);
   assert_write_needs_wel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> wel);
   assert_mode_needs_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seq_mode |-> wel);
   assert_wrdi_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wrdi && !busy) |=> (!wel && !seq_mode));
   assert_wren_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wren && !st_wrdi && !busy) |=> wel);
   assert_busy_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$fell(busy)) |-> ($stable(wel) && $stable(seq_mode)));
endmodule

// File: tb/sim_aai_prog_seq.sv
module sim_aai_prog_seq;
   localparam int AW = 5;
   localparam int BC = 3;
   localparam int NA = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic st_wren = 0, st_wrdi = 0, st_byte = 0, st_seq = 0, st_next = 0;
   logic [AW-1:0] cmd_addr = '0;
   logic [7:0] cmd_data = '0;
   logic [AW-1:0] chk_addr, wr_addr;
   logic chk_protected, wr_req, busy, wel, seq_mode;
   logic [7:0] wr_data;
   int lim = NA;
   int n_chk = 0, n_bad = 0;
   int busy_len;
   logic [7:0] mem [NA];
   logic [7:0] exp_mem [NA];

   always #2 clk = ~clk;

   assign chk_protected = (int'(chk_addr) >= lim);

   aai_prog_seq #(.ADDR_W(AW), .BUSY_CYC(BC)) u0 (
      .clk(clk), .rst_n(rst_n), .st_wren(st_wren), .st_wrdi(st_wrdi),
      .st_byte(st_byte), .st_seq(st_seq), .st_next(st_next),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .chk_addr(chk_addr),
      .chk_protected(chk_protected), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .wel(wel), .seq_mode(seq_mode));

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NA; i++) mem[i] <= 8'hFF;
      end else if (wr_req) begin
         mem[wr_addr] <= wr_data;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // kind: 0 wren 1 wrdi 2 byte 3 seq 4 next
   task automatic send(input int kind, input int a, input int d);
      @(negedge clk);
      cmd_addr = AW'(a);
      cmd_data = 8'(d);
      st_wren = (kind == 0); st_wrdi = (kind == 1); st_byte = (kind == 2);
      st_seq  = (kind == 3); st_next = (kind == 4);
      @(negedge clk);
      st_wren = 0; st_wrdi = 0; st_byte = 0; st_seq = 0; st_next = 0;
      busy_len = 0;
      while (busy) begin
         busy_len++;
         @(negedge clk);
      end
   endtask

   task automatic cmp_mem(input string req);
      for (int i = 0; i < NA; i++)
         chk(mem[i] === exp_mem[i], req, mem[i], exp_mem[i]);
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NA; i++) exp_mem[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, wel, seq_mode} === 3'b000, "reset", {busy, wel, seq_mode}, 0);

      // R1 without latch: nothing written
      send(2, 3, 8'h11);
      chk(busy_len == 0, "R1 no-wel busy", busy_len, 0);
      cmp_mem("R1 no-wel mem");

      // R8, R1, R7 single byte
      send(0, 0, 0);
      chk(wel === 1'b1, "R8 wren", wel, 1);
      send(2, 3, 8'h5A); exp_mem[3] = 8'h5A;
      chk(busy_len == BC, "R7 busy length", busy_len, BC);
      chk(wel === 1'b0, "R1 wel cleared", wel, 0);
      cmp_mem("R1 byte mem");

      // R10 next while inactive
      send(0, 0, 0);
      send(4, 0, 8'h33);
      chk(busy_len == 0, "R10 next inactive", busy_len, 0);
      cmp_mem("R10 mem");

      // R2, R3 sequential run from 10
      send(3, 10, 8'h01); exp_mem[10] = 8'h01;
      chk(busy_len == BC, "R7 seq busy", busy_len, BC);
      chk(seq_mode === 1'b1, "R2 mode set", seq_mode, 1);
      for (int k = 1; k <= 4; k++) begin
         send(4, 0, 8'h01 + k); exp_mem[10 + k] = 8'(8'h01 + k);
      end
      chk(seq_mode === 1'b1 && wel === 1'b1, "R3 still in run", {seq_mode, wel}, 3);
      // R10 byte/seq while in run ignored
      send(2, 1, 8'h77);
      chk(busy_len == 0, "R10 byte in run", busy_len, 0);
      send(3, 2, 8'h77);
      chk(busy_len == 0, "R10 seq in run", busy_len, 0);
      cmp_mem("R3 run mem");

      // R4 write-disable
      send(1, 0, 0);
      chk({seq_mode, wel} === 2'b00, "R4 wrdi", {seq_mode, wel}, 0);
      send(4, 0, 8'h99);
      chk(busy_len == 0, "R4 next after wrdi", busy_len, 0);
      cmp_mem("R4 mem");

      // R5 exit below protected region (lim 24)
      lim = 24;
      send(0, 0, 0);
      send(3, 21, 8'hA1); exp_mem[21] = 8'hA1;
      send(4, 0, 8'hA2);  exp_mem[22] = 8'hA2;
      chk(seq_mode === 1'b1, "R5 not yet at end", seq_mode, 1);
      send(4, 0, 8'hA3);  exp_mem[23] = 8'hA3;
      chk({seq_mode, wel} === 2'b00, "R5 exit at prot", {seq_mode, wel}, 0);
      send(4, 0, 8'hA4);
      chk(busy_len == 0, "R5 no write past end", busy_len, 0);
      cmp_mem("R5 prot mem");

      // R6 protected targets
      send(0, 0, 0);
      send(2, 26, 8'h42);
      chk(busy_len == 0 && wel === 1'b1, "R6 byte prot", {busy_len[3:0], wel}, 1);
      send(3, 24, 8'h42);
      chk(busy_len == 0 && seq_mode === 1'b0, "R6 seq prot", {busy_len[3:0], seq_mode}, 0);
      cmp_mem("R6 mem");

      // R5 exit at top of address space, no wrap
      lim = NA;
      send(3, 30, 8'hB0); exp_mem[30] = 8'hB0;
      send(4, 0, 8'hB1);  exp_mem[31] = 8'hB1;
      chk({seq_mode, wel} === 2'b00, "R5 exit at top", {seq_mode, wel}, 0);
      send(4, 0, 8'hB2);
      chk(busy_len == 0, "R5 no wrap", busy_len, 0);
      cmp_mem("R5 top mem");

      // R9 strobes during busy discarded
      send(0, 0, 0);
      @(negedge clk);
      cmd_addr = 5'd4; cmd_data = 8'h44; st_byte = 1;
      @(negedge clk);
      st_byte = 0; st_wren = 1;
      @(negedge clk);
      st_wren = 0;
      while (busy) @(negedge clk);
      exp_mem[4] = 8'h44;
      chk(wel === 1'b0, "R9 wren in busy", wel, 0);
      send(0, 0, 0);
      send(3, 6, 8'h60); exp_mem[6] = 8'h60;
      @(negedge clk);
      send(4, 0, 8'h61); exp_mem[7] = 8'h61;
      @(negedge clk);
      st_next = 1; cmd_data = 8'h62;
      @(negedge clk);
      st_next = 0; st_wrdi = 1;
      @(negedge clk);
      st_wrdi = 0;
      while (busy) @(negedge clk);
      exp_mem[8] = 8'h62;
      chk(seq_mode === 1'b1, "R9 wrdi in busy", seq_mode, 1);
      send(1, 0, 0);
      cmp_mem("R9 mem");

      // sweep: single byte to every address (R1, R7)
      for (int a = 0; a < NA; a++) begin
         send(0, 0, 0);
         send(2, a, (a * 7 + 3) & 255);
         exp_mem[a] = 8'((a * 7 + 3) & 255);
         chk(busy_len == BC, "R7 sweep busy", busy_len, BC);
         chk(wel === 1'b0, "R1 sweep wel", wel, 0);
      end
      cmp_mem("R1 sweep mem");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule